// File: doc/BRIEF.md
# Two-Way Set-Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations. A requester presents a 48-bit virtual address and a read/write flag. The block keeps the low 14 bits as the in-page offset and treats the upper 34 bits as the virtual page number. Seven bits of that page number select one of 128 sets. The other 27 bits are the tag, and it is compared against both ways of the chosen set at once. On a hit, the response one cycle later carries the stored 18-bit frame number joined to the untouched offset.

On a miss the block stalls new lookups. It asks an external page-table walker for the page number and waits for the reply. If the reply carries no fault, the block installs the returned frame and status bits into the set and completes the original request with that translation.

Each entry holds four status bits: valid, write-permitted, dirty and used. Write accesses are flagged rather than completed silently. A write to a read-only page reports a fault. A write to a writable clean page reports a dirty update and marks the entry dirty. A flush input drops every entry in a single cycle.

Top module: `tlb_xlate`

## Requirements
- R1: The set index is virtual address bits [20:14] and the tag is bits [47:21]. The physical address of a translation is {frame[17:0], vaddr[13:0]}. The same tag in a different set does not hit.
- R2: A lookup hits only when the indexed entry is valid and its tag is equal. `resp_valid` and `resp_hit` rise in the cycle after the accepted request.
- R3: On a miss, `walk_req_valid` is high from the cycle after acceptance, with `walk_req_vpn` = vaddr[47:14]. It stays high and stable, with `req_ready` low, until `walk_rsp_valid`.
- R4: In the cycle after `walk_rsp_valid` without fault, `resp_valid` is 1, `resp_hit` is 0 and `resp_paddr` = {walk_rsp_pfn, offset}. The entry is installed, so a repeated lookup hits.
- R5: A walk reply with `walk_rsp_fault` = 1 responds with `resp_fault` = 1 and `resp_paddr` = 0. It installs nothing, so a repeated lookup misses again.
- R6: A refill fills an invalid way first. When both ways are valid, it evicts the way used least recently, where both hits and refills count as uses.
- R7: A write that hits an entry without write permission responds with `resp_fault` = 1 and `resp_dirty_upd` = 0. A read of that entry reports no fault.
- R8: A write to a writable clean entry responds with `resp_dirty_upd` = 1 and sets the entry's dirty bit, so the next write reports neither flag. The same applies when the write refills the entry.
- R9: `flush` invalidates every entry in one cycle, and `req_ready` is low during that cycle.
- R10: At most one way of a set matches a lookup.
- R11: After reset, `req_ready` = 1, `resp_valid` = 0, `walk_req_valid` = 0 and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Lookup is a write access |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| resp_valid | output | 1 | Response strobe |
| resp_paddr | output | 32 | Translated physical address |
| resp_hit | output | 1 | Response came from a stored entry |
| resp_fault | output | 1 | Walk fault or write to read-only page |
| resp_dirty_upd | output | 1 | First write to a clean writable page |
| walk_req_valid | output | 1 | Page-table walk request |
| walk_req_vpn | output | 34 | Virtual page number to walk |
| walk_rsp_valid | input | 1 | Walk reply strobe |
| walk_rsp_pfn | input | 18 | Returned frame number |
| walk_rsp_wr_ok | input | 1 | Returned page is writable |
| walk_rsp_dirty | input | 1 | Returned page is already dirty |
| walk_rsp_fault | input | 1 | Walk failed |

## Verification
Lookups are issued against a single set that is first empty, then half full, then full with alternating recency. These patterns separate the invalid-first choice from the least-recently-used choice. An address that shares a tag with a stored page but falls in a neighbouring set checks that the index field, and not the tag alone, selects the entry. Read and write accesses are tried against read-only, clean-writable and dirty-writable pages, both on hits and on refills, so the fault and dirty-update flags are each seen alone. Walk replies with and without a fault, and a flush followed by a lookup, show whether an entry is installed or removed.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef struct packed {
        logic valid;
        logic wr_ok;
        logic dirty;
        logic used;
    } tlb_status_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } tlb_state_e;

endpackage

// File: rtl/tlb_way.sv
module tlb_way
    import tlb_pkg::*;
#(
    parameter int TAG_W = 27,
    parameter int PFN_W = 18,
    parameter int SET_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [SET_W-1:0]   rd_idx,
    input  logic [TAG_W-1:0]   rd_tag,
    output logic               hit,
    output logic [PFN_W-1:0]   rd_pfn,
    output tlb_status_t        rd_st,
    input  logic               wr_en,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  tlb_status_t        wr_st
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0] tag_q [SETS];
    logic [TAG_W-1:0] tag_d [SETS];
    logic [PFN_W-1:0] pfn_q [SETS];
    logic [PFN_W-1:0] pfn_d [SETS];
    tlb_status_t      st_q  [SETS];
    tlb_status_t      st_d  [SETS];
    logic [SETS-1:0]  vld_vec;

    // Read port: the whole set entry for the indexed row
    assign rd_st  = st_q[rd_idx];
    assign rd_pfn = pfn_q[rd_idx];
    assign hit    = st_q[rd_idx].valid && (tag_q[rd_idx] == rd_tag);

    // Next state: flush clears valids, then a write (same cycle) wins
    always_comb begin
        tag_d = tag_q;
        pfn_d = pfn_q;
        st_d  = st_q;
        if (flush) begin
            for (int i = 0; i < SETS; i++) begin
                st_d[i].valid = 1'b0;
            end
        end
        if (wr_en) begin
            tag_d[rd_idx] = wr_tag;
            pfn_d[rd_idx] = wr_pfn;
            st_d[rd_idx]  = wr_st;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                st_q[i] <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
        pfn_q <= pfn_d;
    end

    always_comb begin
        for (int i = 0; i < SETS; i++) begin
            vld_vec[i] = st_q[i].valid;
        end
    end

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !wr_en) |=> (vld_vec == '0));

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int SET_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] idx,
    input  logic [1:0]       way_valid,
    output logic             victim,
    input  logic             upd_en,
    input  logic             upd_way
);
    localparam int SETS = 1 << SET_W;

    // Per set: the way to evict next
    logic [SETS-1:0] evict_q, evict_d;

    always_comb begin
        if (!way_valid[0])      victim = 1'b0;
        else if (!way_valid[1]) victim = 1'b1;
        else                    victim = evict_q[idx];
    end

    always_comb begin
        evict_d = evict_q;
        if (upd_en) begin
            evict_d[idx] = ~upd_way;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) evict_q <= '0;
        else        evict_q <= evict_d;
    end

    // R6
    victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (way_valid != 2'b11) |-> !way_valid[victim]);

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W     = 48,
    parameter int PA_W     = 32,
    parameter int PG_OFF_W = 14,
    parameter int SET_W    = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         req_valid,
    input  logic [VA_W-1:0]              req_vaddr,
    input  logic                         req_write,
    output logic                         req_ready,
    output logic                         resp_valid,
    output logic [PA_W-1:0]              resp_paddr,
    output logic                         resp_hit,
    output logic                         resp_fault,
    output logic                         resp_dirty_upd,
    output logic                         walk_req_valid,
    output logic [VA_W-PG_OFF_W-1:0]     walk_req_vpn,
    input  logic                         walk_rsp_valid,
    input  logic [PA_W-PG_OFF_W-1:0]     walk_rsp_pfn,
    input  logic                         walk_rsp_wr_ok,
    input  logic                         walk_rsp_dirty,
    input  logic                         walk_rsp_fault
);
    localparam int VPN_W = VA_W - PG_OFF_W;
    localparam int TAG_W = VPN_W - SET_W;
    localparam int PFN_W = PA_W - PG_OFF_W;
    localparam int NWAY  = 2;

    typedef struct packed {
        tlb_state_e            state;
        logic                  rsp_v;
        logic [PA_W-1:0]       pa;
        logic                  hit;
        logic                  fault;
        logic                  dupd;
        logic [VPN_W-1:0]      vpn;
        logic [PG_OFF_W-1:0]   off;
        logic                  wr;
    } ctl_t;

    ctl_t c_q, c_d;

    logic [SET_W-1:0] rd_idx;
    logic [TAG_W-1:0] rd_tag;
    logic [NWAY-1:0]  way_hit;
    logic [NWAY-1:0]  way_valid;
    logic [NWAY-1:0]  wr_en;
    logic [PFN_W-1:0] way_pfn [NWAY];
    tlb_status_t      way_st  [NWAY];
    logic [PFN_W-1:0] wr_pfn;
    tlb_status_t      wr_st;
    logic             victim;
    logic             upd_en;
    logic             upd_way;
    logic             hit_way;
    logic [PFN_W-1:0] sel_pfn;
    tlb_status_t      sel_st;
    logic             accept;
    logic             acc_dupd;

    assign req_ready = (c_q.state == ST_IDLE) && !flush;
    assign accept    = req_valid && req_ready;

    // Lookup field split: from the port when idle, from the pending page when walking
    assign rd_idx = (c_q.state == ST_IDLE) ? req_vaddr[PG_OFF_W +: SET_W]
                                           : c_q.vpn[SET_W-1:0];
    assign rd_tag = (c_q.state == ST_IDLE) ? req_vaddr[VA_W-1 -: TAG_W]
                                           : c_q.vpn[VPN_W-1 -: TAG_W];

    genvar gw;
    generate
        for (gw = 0; gw < NWAY; gw++) begin : g_way
            tlb_way #(
                .TAG_W (TAG_W),
                .PFN_W (PFN_W),
                .SET_W (SET_W)
            ) u_way (
                .clk    (clk),
                .rst_n  (rst_n),
                .flush  (flush),
                .rd_idx (rd_idx),
                .rd_tag (rd_tag),
                .hit    (way_hit[gw]),
                .rd_pfn (way_pfn[gw]),
                .rd_st  (way_st[gw]),
                .wr_en  (wr_en[gw]),
                .wr_tag (rd_tag),
                .wr_pfn (wr_pfn),
                .wr_st  (wr_st)
            );
            assign way_valid[gw] = way_st[gw].valid;
        end
    endgenerate

    tlb_lru #(
        .SET_W (SET_W)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (rd_idx),
        .way_valid (way_valid),
        .victim    (victim),
        .upd_en    (upd_en),
        .upd_way   (upd_way)
    );

    assign hit_way = way_hit[1];
    assign sel_pfn = way_pfn[hit_way];
    assign sel_st  = way_st[hit_way];

    always_comb begin
        c_d      = c_q;
        c_d.rsp_v = 1'b0;
        wr_en    = '0;
        wr_pfn   = '0;
        wr_st    = '0;
        upd_en   = 1'b0;
        upd_way  = 1'b0;
        acc_dupd = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (accept) begin
                    c_d.vpn = req_vaddr[VA_W-1:PG_OFF_W];
                    c_d.off = req_vaddr[PG_OFF_W-1:0];
                    c_d.wr  = req_write;
                    if (|way_hit) begin
                        acc_dupd      = req_write && sel_st.wr_ok && !sel_st.dirty;
                        c_d.rsp_v     = 1'b1;
                        c_d.hit       = 1'b1;
                        c_d.pa        = {sel_pfn, req_vaddr[PG_OFF_W-1:0]};
                        c_d.fault     = req_write && !sel_st.wr_ok;
                        c_d.dupd      = acc_dupd;
                        wr_en[hit_way] = 1'b1;
                        wr_pfn        = sel_pfn;
                        wr_st         = sel_st;
                        wr_st.used    = 1'b1;
                        wr_st.dirty   = sel_st.dirty | acc_dupd;
                        upd_en        = 1'b1;
                        upd_way       = hit_way;
                    end else begin
                        c_d.state = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                if (walk_rsp_valid) begin
                    c_d.state = ST_IDLE;
                    c_d.rsp_v = 1'b1;
                    c_d.hit   = 1'b0;
                    if (walk_rsp_fault) begin
                        c_d.pa    = '0;
                        c_d.fault = 1'b1;
                        c_d.dupd  = 1'b0;
                    end else begin
                        acc_dupd      = c_q.wr && walk_rsp_wr_ok && !walk_rsp_dirty;
                        c_d.pa        = {walk_rsp_pfn, c_q.off};
                        c_d.fault     = c_q.wr && !walk_rsp_wr_ok;
                        c_d.dupd      = acc_dupd;
                        wr_en[victim] = 1'b1;
                        wr_pfn        = walk_rsp_pfn;
                        wr_st.valid   = 1'b1;
                        wr_st.wr_ok   = walk_rsp_wr_ok;
                        wr_st.dirty   = walk_rsp_dirty | acc_dupd;
                        wr_st.used    = 1'b1;
                        upd_en        = 1'b1;
                        upd_way       = victim;
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign resp_valid     = c_q.rsp_v;
    assign resp_paddr     = c_q.pa;
    assign resp_hit       = c_q.hit;
    assign resp_fault     = c_q.fault;
    assign resp_dirty_upd = c_q.dupd;
    assign walk_req_valid = (c_q.state == ST_WALK);
    assign walk_req_vpn   = c_q.vpn;

    // R10
    way_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    // R2
    hit_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (|way_hit)) |=> (resp_valid && resp_hit));

    // R3
    walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && !walk_rsp_valid) |=> (walk_req_valid && $stable(walk_req_vpn)));

    // R3
    walk_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req_valid |-> !req_ready);

    // R5
    walk_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_req_valid && walk_rsp_valid && walk_rsp_fault) |=>
            (resp_valid && resp_fault && !resp_hit));

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !(resp_fault && resp_dirty_upd));

endmodule

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush;
    logic        req_valid;
    logic [47:0] req_vaddr;
    logic        req_write;
    logic        req_ready;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_hit;
    logic        resp_fault;
    logic        resp_dirty_upd;
    logic        walk_req_valid;
    logic [33:0] walk_req_vpn;
    logic        walk_rsp_valid;
    logic [17:0] walk_rsp_pfn;
    logic        walk_rsp_wr_ok;
    logic        walk_rsp_dirty;
    logic        walk_rsp_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tlb_xlate dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .req_write      (req_write),
        .req_ready      (req_ready),
        .resp_valid     (resp_valid),
        .resp_paddr     (resp_paddr),
        .resp_hit       (resp_hit),
        .resp_fault     (resp_fault),
        .resp_dirty_upd (resp_dirty_upd),
        .walk_req_valid (walk_req_valid),
        .walk_req_vpn   (walk_req_vpn),
        .walk_rsp_valid (walk_rsp_valid),
        .walk_rsp_pfn   (walk_rsp_pfn),
        .walk_rsp_wr_ok (walk_rsp_wr_ok),
        .walk_rsp_dirty (walk_rsp_dirty),
        .walk_rsp_fault (walk_rsp_fault)
    );

    function automatic logic [47:0] mk_va(input logic [26:0] tag, input logic [6:0] set,
                                          input logic [13:0] off);
        return {tag, set, off};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [47:0] va, input logic wr, input string req);
        @(negedge clk);
        chk(req_ready == 1'b1, req, "req_ready before issue", 64'(req_ready), 64'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic do_hit(input logic [47:0] va, input logic wr, input logic [17:0] pfn,
                          input logic efault, input logic edupd, input string req);
        issue(va, wr, req);
        chk(resp_valid && resp_hit, req, "hit response", {62'd0, resp_valid, resp_hit}, 64'd3);
        chk(resp_paddr == {pfn, va[13:0]}, req, "hit paddr", 64'(resp_paddr), 64'({pfn, va[13:0]}));
        chk(resp_fault == efault && resp_dirty_upd == edupd, req, "hit flags",
            {62'd0, resp_fault, resp_dirty_upd}, {62'd0, efault, edupd});
    endtask

    task automatic do_miss(input logic [47:0] va, input logic wr, input logic [17:0] pfn,
                           input logic wok, input logic dty, input logic flt,
                           input logic efault, input logic edupd, input string req);
        logic [31:0] epa;
        issue(va, wr, req);
        chk(!resp_valid, req, "no response on miss", 64'(resp_valid), 64'd0);
        chk(walk_req_valid && walk_req_vpn == va[47:14], req, "walk request",
            64'(walk_req_vpn), 64'(va[47:14]));
        @(negedge clk);
        chk(walk_req_valid && walk_req_vpn == va[47:14] && !req_ready, req, "walk held, stalled",
            {61'd0, walk_req_valid, req_ready, 1'b0}, 64'd4);
        walk_rsp_valid = 1'b1;
        walk_rsp_pfn   = pfn;
        walk_rsp_wr_ok = wok;
        walk_rsp_dirty = dty;
        walk_rsp_fault = flt;
        @(negedge clk);
        walk_rsp_valid = 1'b0;
        walk_rsp_fault = 1'b0;
        epa = flt ? 32'd0 : {pfn, va[13:0]};
        chk(resp_valid && !resp_hit, req, "refill response", {62'd0, resp_valid, resp_hit}, 64'd2);
        chk(resp_paddr == epa, req, "refill paddr", 64'(resp_paddr), 64'(epa));
        chk(resp_fault == efault && resp_dirty_upd == edupd, req, "refill flags",
            {62'd0, resp_fault, resp_dirty_upd}, {62'd0, efault, edupd});
        chk(!walk_req_valid, req, "walk released", 64'(walk_req_valid), 64'd0);
    endtask

    task automatic t_reset();
        chk(req_ready && !resp_valid && !walk_req_valid, "R11", "reset outputs",
            {61'd0, req_ready, resp_valid, walk_req_valid}, 64'd4);
    endtask

    // R3 R4 R1 R2: first fill, then hit with another offset
    task automatic t_fill_and_hit();
        do_miss(mk_va(27'h1, 7'd5, 14'h0123), 1'b0, 18'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        do_hit (mk_va(27'h1, 7'd5, 14'h3ABC), 1'b0, 18'h1234, 1'b0, 1'b0, "R1");
        // R1: same tag, neighbouring set misses
        do_miss(mk_va(27'h1, 7'd6, 14'h0001), 1'b0, 18'h0777, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    endtask

    // R6: invalid way first, then least recently used
    task automatic t_replace();
        do_miss(mk_va(27'h2, 7'd5, 14'h0010), 1'b0, 18'h2222, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        do_hit (mk_va(27'h1, 7'd5, 14'h0020), 1'b0, 18'h1234, 1'b0, 1'b0, "R6");
        do_hit (mk_va(27'h2, 7'd5, 14'h0030), 1'b0, 18'h2222, 1'b0, 1'b0, "R6");
        do_hit (mk_va(27'h1, 7'd5, 14'h0040), 1'b0, 18'h1234, 1'b0, 1'b0, "R6");
        // tag 2 is now least recent: tag 3 replaces it
        do_miss(mk_va(27'h3, 7'd5, 14'h0050), 1'b0, 18'h3333, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        do_hit (mk_va(27'h3, 7'd5, 14'h0060), 1'b0, 18'h3333, 1'b0, 1'b0, "R6");
        do_hit (mk_va(27'h1, 7'd5, 14'h0070), 1'b0, 18'h1234, 1'b0, 1'b0, "R6");
    endtask

    // R5: faulted walk installs nothing; tag 2 then refills over tag 3
    task automatic t_walk_fault();
        do_miss(mk_va(27'h2, 7'd5, 14'h0080), 1'b0, 18'h2AAA, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
        do_miss(mk_va(27'h2, 7'd5, 14'h0090), 1'b0, 18'h2BBB, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        do_hit (mk_va(27'h1, 7'd5, 14'h00A0), 1'b0, 18'h1234, 1'b0, 1'b0, "R6");
    endtask

    // R7: read-only page
    task automatic t_readonly();
        do_miss(mk_va(27'h44, 7'd9, 14'h0004), 1'b0, 18'h0ABC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        do_hit (mk_va(27'h44, 7'd9, 14'h0008), 1'b1, 18'h0ABC, 1'b1, 1'b0, "R7");
        do_hit (mk_va(27'h44, 7'd9, 14'h000C), 1'b0, 18'h0ABC, 1'b0, 1'b0, "R7");
        do_miss(mk_va(27'h45, 7'd10, 14'h0004), 1'b1, 18'h0DEF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    endtask

    // R8: dirty update on hit and on refill
    task automatic t_dirty();
        do_hit (mk_va(27'h1, 7'd5, 14'h0100), 1'b1, 18'h1234, 1'b0, 1'b1, "R8");
        do_hit (mk_va(27'h1, 7'd5, 14'h0104), 1'b1, 18'h1234, 1'b0, 1'b0, "R8");
        do_miss(mk_va(27'h7, 7'd20, 14'h0200), 1'b1, 18'h3F00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
        do_hit (mk_va(27'h7, 7'd20, 14'h0204), 1'b1, 18'h3F00, 1'b0, 1'b0, "R8");
    endtask

    // R9: flush drops entries and blocks the cycle
    task automatic t_flush();
        @(negedge clk);
        flush = 1'b1;
        #1;
        chk(!req_ready, "R9", "ready during flush", 64'(req_ready), 64'd0);
        @(negedge clk);
        flush = 1'b0;
        do_miss(mk_va(27'h1, 7'd5, 14'h0300), 1'b0, 18'h0555, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        do_miss(mk_va(27'h7, 7'd20, 14'h0301), 1'b0, 18'h0666, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
        do_hit (mk_va(27'h1, 7'd5, 14'h0302), 1'b0, 18'h0555, 1'b0, 1'b0, "R9");
    endtask

    initial begin
        rst_n = 1'b0;
        flush = 1'b0;
        req_valid = 1'b0;
        req_vaddr = '0;
        req_write = 1'b0;
        walk_rsp_valid = 1'b0;
        walk_rsp_pfn = '0;
        walk_rsp_wr_ok = 1'b0;
        walk_rsp_dirty = 1'b0;
        walk_rsp_fault = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_hit();
        t_replace();
        t_walk_fault();
        t_readonly();
        t_dirty();
        t_flush();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule